// File: doc/BRIEF.md
# Multi-channel scan conversion sequencer

This block drives an analog-to-digital converter through a set of input channels picked by a 32-bit channel mask. Starting from the lowest selected channel and moving upward, it issues one conversion request per selected channel. Each result is handed to the result FIFO together with its channel number and a source tag. A one-shot run makes a single pass over the mask. With the repeat control set, the sequencer wraps back to the lowest selected channel after each pass. Clearing the repeat control lets the current pass finish and then stops.

Single priority conversions at two levels can cut into a running scan, and they can also run while no scan is active. A pending priority request is served at the next boundary between channels. The scan then picks up at the channel after the last one it completed. A forced-stop strobe stops everything at once. It cancels the conversion in flight, drops pending priority requests and clears both status flags.

The converter is reached through a request/done handshake with a 12-bit result and an abort strobe. Two read-only flags report scan and priority activity.

Top module: `scan_seq`

## Requirements
- R1: After reset, scan_busy_o, prio_busy_o, conv_req_o, conv_abort_o and fifo_wr_o are all 0.
- R2: A start strobe latches the mask and converts every selected channel exactly once per pass, in ascending channel order. Each result is written with fifo_src_o = 2'b00 and its channel number on fifo_ch_o.
- R3: Each written result carries the data the converter returned for that request, and the channel that was requested.
- R4: In one-shot mode (repeat_i = 0 when the last selected channel completes), scan_busy_o falls in the same cycle the last result is written, and no further conversion is requested.
- R5: If repeat_i is 1 when the last selected channel completes, the scan continues from the lowest selected channel.
- R6: repeat_i is sampled only at the end of a pass. Clearing it mid-pass lets that pass finish, and then the scan stops.
- R7: A start strobe with an all-zero mask is ignored. A start strobe while a scan is running is ignored, and the latched mask is unchanged.
- R8: A forced stop (stop_i) clears scan_busy_o and prio_busy_o on the next cycle, pulses conv_abort_o, and writes no result for the conversion in flight. It overrides any start or request in the same cycle.
- R9: Priority requests are granted only at a channel boundary, with level 1 before level 2. Results carry fifo_src_o = 2'b01 for level 1 and 2'b10 for level 2, with the requested channel.
- R10: After priority conversions, the scan resumes at the channel after the last one it completed.
- R11: prio_busy_o is 1 while a level 1 or level 2 request is pending or being converted, with or without a scan running.
- R12: At most one conversion is outstanding at a time. conv_req_o is a single-cycle pulse and is never issued while a request is still awaiting conv_done_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Scan start strobe |
| repeat_i | input | 1 | Repeat-mode control level |
| stop_i | input | 1 | Forced-stop strobe |
| mask_i | input | 32 | Channel selection mask, bit n selects channel n |
| prio1_req_i | input | 1 | Level 1 priority request strobe |
| prio1_ch_i | input | 5 | Level 1 priority channel |
| prio2_req_i | input | 1 | Level 2 priority request strobe |
| prio2_ch_i | input | 5 | Level 2 priority channel |
| conv_req_o | output | 1 | Conversion request pulse |
| conv_ch_o | output | 5 | Channel to convert |
| conv_abort_o | output | 1 | Cancel the outstanding conversion |
| conv_done_i | input | 1 | Conversion complete pulse |
| conv_data_i | input | 12 | Conversion result |
| fifo_wr_o | output | 1 | Result write strobe |
| fifo_data_o | output | 12 | Result data |
| fifo_ch_o | output | 5 | Result channel |
| fifo_src_o | output | 2 | Result source: 00 scan, 01 level 1, 10 level 2 |
| scan_busy_o | output | 1 | Scan in progress |
| prio_busy_o | output | 1 | Priority conversion pending or running |

## Verification
The assertions assume a well-behaved converter. It raises conv_done_i for exactly one cycle per request, no earlier than the cycle after conv_req_o, never with no request outstanding, and never for a conversion cancelled by conv_abort_o. The bench converter model follows this by holding a countdown armed only by a request and cleared by the abort strobe. The bench issues a priority request only after that level's previous result has come back. It changes repeat_i only between the results of a pass, so that the bench's own expected channel order matches the design's end-of-pass sampling.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;
  localparam int unsigned N_CH_DEF   = 32;
  localparam int unsigned DATA_W_DEF = 12;

  typedef enum logic [1:0] {
    SRC_SCAN  = 2'b00,
    SRC_PRIO1 = 2'b01,
    SRC_PRIO2 = 2'b10
  } src_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } state_e;
endpackage

// File: rtl/scan_seq_pick.sv
// lowest set mask bit at or above from_i
module scan_seq_pick #(
  parameter int N_CH = 32,
  localparam int CH_W = $clog2(N_CH)
) (
  input  logic [N_CH-1:0] mask_i,
  input  logic [CH_W:0]   from_i,
  output logic            found_o,
  output logic [CH_W-1:0] idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = N_CH - 1; i >= 0; i--) begin
      if (mask_i[i] && ((CH_W+1)'(i) >= from_i)) begin
        found_o = 1'b1;
        idx_o   = CH_W'(i);
      end
    end
  end
endmodule

// File: rtl/scan_seq_prio.sv
module scan_seq_prio #(
  parameter int CH_W = 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clear_i,
  input  logic            req1_i,
  input  logic [CH_W-1:0] ch1_i,
  input  logic            req2_i,
  input  logic [CH_W-1:0] ch2_i,
  input  logic            grant_i,
  output logic            pend_o,
  output logic            lvl2_o,
  output logic [CH_W-1:0] ch_o
);
  logic            pend1_q, pend2_q;
  logic [CH_W-1:0] ch1_q, ch2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend1_q <= 1'b0;
      pend2_q <= 1'b0;
      ch1_q   <= '0;
      ch2_q   <= '0;
    end else if (clear_i) begin
      pend1_q <= 1'b0;
      pend2_q <= 1'b0;
    end else begin
      if (grant_i && pend1_q) begin
        pend1_q <= 1'b0;
      end else if (req1_i && !pend1_q) begin
        pend1_q <= 1'b1;
        ch1_q   <= ch1_i;
      end
      if (grant_i && !pend1_q && pend2_q) begin
        pend2_q <= 1'b0;
      end else if (req2_i && !pend2_q) begin
        pend2_q <= 1'b1;
        ch2_q   <= ch2_i;
      end
    end
  end

  assign pend_o = pend1_q | pend2_q;
  assign lvl2_o = !pend1_q;
  assign ch_o   = pend1_q ? ch1_q : ch2_q;

  // grants come only for a waiting request
  assert_grant_pending_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_i |-> pend_o);
  // a waiting level 1 request is held until granted or cleared
  assert_lvl1_held_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend1_q && !grant_i && !clear_i |=> pend1_q);
endmodule

// File: rtl/scan_seq_result.sv
module scan_seq_result #(
  parameter int CH_W   = 5,
  parameter int DATA_W = 12
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clear_i,
  input  logic                load_i,
  input  logic [DATA_W-1:0]   data_i,
  input  logic [CH_W-1:0]     ch_i,
  input  scan_seq_pkg::src_e  src_i,
  output logic                wr_o,
  output logic [DATA_W-1:0]   data_o,
  output logic [CH_W-1:0]     ch_o,
  output scan_seq_pkg::src_e  src_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_o   <= 1'b0;
      data_o <= '0;
      ch_o   <= '0;
      src_o  <= scan_seq_pkg::SRC_SCAN;
    end else begin
      wr_o <= load_i && !clear_i;
      if (load_i) begin
        data_o <= data_i;
        ch_o   <= ch_i;
        src_o  <= src_i;
      end
    end
  end

  assert_no_write_after_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> !wr_o);
endmodule

// File: rtl/scan_seq.sv
module scan_seq
  import scan_seq_pkg::*;
#(
  parameter int N_CH   = N_CH_DEF,
  parameter int DATA_W = DATA_W_DEF,
  localparam int CH_W  = $clog2(N_CH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              repeat_i,
  input  logic              stop_i,
  input  logic [N_CH-1:0]   mask_i,
  input  logic              prio1_req_i,
  input  logic [CH_W-1:0]   prio1_ch_i,
  input  logic              prio2_req_i,
  input  logic [CH_W-1:0]   prio2_ch_i,
  output logic              conv_req_o,
  output logic [CH_W-1:0]   conv_ch_o,
  output logic              conv_abort_o,
  input  logic              conv_done_i,
  input  logic [DATA_W-1:0] conv_data_i,
  output logic              fifo_wr_o,
  output logic [DATA_W-1:0] fifo_data_o,
  output logic [CH_W-1:0]   fifo_ch_o,
  output logic [1:0]        fifo_src_o,
  output logic              scan_busy_o,
  output logic              prio_busy_o
);
  state_e          state_q;
  logic            scan_on_q;
  logic [N_CH-1:0] mask_q;
  logic [CH_W-1:0] next_ch_q;
  src_e            cur_src_q;
  logic [CH_W-1:0] cur_ch_q;
  logic            req_q, abort_q;

  logic [N_CH-1:0] first_mask;
  logic            first_found, after_found;
  logic [CH_W-1:0] first_idx, after_idx;
  logic [CH_W:0]   after_from;
  logic            pend, lvl2;
  logic [CH_W-1:0] prio_ch;
  logic            issue_prio, issue_scan, done_ok, start_ok;
  src_e            res_src;

  assign first_mask = scan_on_q ? mask_q : mask_i;
  assign after_from = {1'b0, cur_ch_q} + 1'b1;

  scan_seq_pick #(.N_CH(N_CH)) u_pick_first (
    .mask_i (first_mask),
    .from_i ('0),
    .found_o(first_found),
    .idx_o  (first_idx)
  );

  scan_seq_pick #(.N_CH(N_CH)) u_pick_after (
    .mask_i (mask_q),
    .from_i (after_from),
    .found_o(after_found),
    .idx_o  (after_idx)
  );

  scan_seq_prio #(.CH_W(CH_W)) u_prio (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(stop_i),
    .req1_i (prio1_req_i),
    .ch1_i  (prio1_ch_i),
    .req2_i (prio2_req_i),
    .ch2_i  (prio2_ch_i),
    .grant_i(issue_prio),
    .pend_o (pend),
    .lvl2_o (lvl2),
    .ch_o   (prio_ch)
  );

  assign issue_prio = (state_q == ST_IDLE) && !stop_i && pend;
  assign issue_scan = (state_q == ST_IDLE) && !stop_i && !pend && scan_on_q;
  assign done_ok    = (state_q == ST_BUSY) && conv_done_i && !stop_i;
  assign start_ok   = start_i && !stop_i && !scan_on_q && first_found;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      scan_on_q <= 1'b0;
      mask_q    <= '0;
      next_ch_q <= '0;
      cur_src_q <= SRC_SCAN;
      cur_ch_q  <= '0;
      req_q     <= 1'b0;
      abort_q   <= 1'b0;
    end else if (stop_i) begin
      state_q   <= ST_IDLE;
      scan_on_q <= 1'b0;
      req_q     <= 1'b0;
      abort_q   <= 1'b1;
    end else begin
      abort_q <= 1'b0;
      req_q   <= issue_prio || issue_scan;
      if (issue_prio) begin
        state_q   <= ST_BUSY;
        cur_src_q <= lvl2 ? SRC_PRIO2 : SRC_PRIO1;
        cur_ch_q  <= prio_ch;
      end else if (issue_scan) begin
        state_q   <= ST_BUSY;
        cur_src_q <= SRC_SCAN;
        cur_ch_q  <= next_ch_q;
      end
      if (done_ok) begin
        state_q <= ST_IDLE;
        if (cur_src_q == SRC_SCAN) begin
          if (after_found)   next_ch_q <= after_idx;
          else if (repeat_i) next_ch_q <= first_idx;  // wrap for repeat
          else               scan_on_q <= 1'b0;
        end
      end
      if (start_ok) begin
        scan_on_q <= 1'b1;
        mask_q    <= mask_i;
        next_ch_q <= first_idx;
      end
    end
  end

  scan_seq_result #(.CH_W(CH_W), .DATA_W(DATA_W)) u_result (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(stop_i),
    .load_i (done_ok),
    .data_i (conv_data_i),
    .ch_i   (cur_ch_q),
    .src_i  (cur_src_q),
    .wr_o   (fifo_wr_o),
    .data_o (fifo_data_o),
    .ch_o   (fifo_ch_o),
    .src_o  (res_src)
  );

  assign fifo_src_o   = res_src;
  assign conv_req_o   = req_q;
  assign conv_ch_o    = cur_ch_q;
  assign conv_abort_o = abort_q;
  assign scan_busy_o  = scan_on_q;
  assign prio_busy_o  = pend || ((state_q == ST_BUSY) && (cur_src_q != SRC_SCAN));

  assert_single_req_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_req_o |=> !conv_req_o);
  // input assumption: done only while a conversion is outstanding
  assert_done_while_busy_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_done_i && !stop_i |-> state_q == ST_BUSY);
  assert_stop_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !scan_busy_o && !prio_busy_o && !fifo_wr_o && conv_abort_o);
  assert_scan_tag_in_mask_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_wr_o && (fifo_src_o == SRC_SCAN) |-> mask_q[fifo_ch_o]);
  assert_zero_start_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !scan_busy_o && (mask_i == '0) |=> !scan_busy_o);
  assert_busy_start_keeps_mask_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scan_busy_o && !stop_i |=> $stable(mask_q));
  assert_oneshot_end_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(scan_busy_o) && !$past(stop_i) |-> fifo_wr_o && (fifo_src_o == SRC_SCAN));
  assert_grant_at_boundary_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_req_o |-> $past(state_q) == ST_IDLE);
endmodule

// File: tb/scan_seq_bench.sv
module scan_seq_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0, repeat_i = 1'b0, stop_i = 1'b0;
  logic [31:0] mask_i = '0;
  logic        prio1_req_i = 1'b0, prio2_req_i = 1'b0;
  logic [4:0]  prio1_ch_i = '0, prio2_ch_i = '0;
  logic        conv_req_o, conv_abort_o, conv_done_i = 1'b0;
  logic [4:0]  conv_ch_o;
  logic [11:0] conv_data_i = '0;
  logic        fifo_wr_o;
  logic [11:0] fifo_data_o;
  logic [4:0]  fifo_ch_o;
  logic [1:0]  fifo_src_o;
  logic        scan_busy_o, prio_busy_o;

  always #2 clk_i = ~clk_i;

  scan_seq u_scan_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .repeat_i(repeat_i),
    .stop_i(stop_i), .mask_i(mask_i), .prio1_req_i(prio1_req_i),
    .prio1_ch_i(prio1_ch_i), .prio2_req_i(prio2_req_i), .prio2_ch_i(prio2_ch_i),
    .conv_req_o(conv_req_o), .conv_ch_o(conv_ch_o), .conv_abort_o(conv_abort_o),
    .conv_done_i(conv_done_i), .conv_data_i(conv_data_i), .fifo_wr_o(fifo_wr_o),
    .fifo_data_o(fifo_data_o), .fifo_ch_o(fifo_ch_o), .fifo_src_o(fifo_src_o),
    .scan_busy_o(scan_busy_o), .prio_busy_o(prio_busy_o)
  );

  int checks = 0, bad = 0;
  int lat_mode = 0, cv_cnt = 0, req_cnt = 0, req_ch_b = 0;
  logic [11:0] last_data = '0;
  logic [31:0] scan_mask_b = '0;
  bit   rep_b = 0;
  int   exp_scan = -1, scan_res = 0, sweeps = 0, log_n = 0;
  int   p_ch_b[3];
  bit   p_out[3];
  int   log_src[64], log_ch[64];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic int next_set(input logic [31:0] m, input int from);
    for (int i = from; i < 32; i++) if (m[i]) return i;
    return 32;
  endfunction

  function automatic int popc(input logic [31:0] m);
    int n = 0;
    for (int i = 0; i < 32; i++) n += int'(m[i]);
    return n;
  endfunction

  // converter model
  always @(negedge clk_i) begin
    if (!rst_ni) begin
      cv_cnt = 0;
      conv_done_i = 1'b0;
    end else begin
      conv_done_i = 1'b0;
      if (conv_abort_o) cv_cnt = 0;
      else if (cv_cnt > 0) begin
        cv_cnt--;
        if (cv_cnt == 0) begin
          conv_done_i = 1'b1;
          conv_data_i = 12'($urandom % 4096);
          last_data = conv_data_i;
        end
      end
      if (conv_req_o) begin
        req_cnt++;
        req_ch_b = int'(conv_ch_o);
        cv_cnt = (lat_mode == 0) ? 1 + int'($urandom % 4) : lat_mode;
      end
    end
  end

  // result monitor
  always @(negedge clk_i) begin
    if (rst_ni && fifo_wr_o) begin
      int nx, lvl;
      log_src[log_n % 64] = int'(fifo_src_o);
      log_ch[log_n % 64]  = int'(fifo_ch_o);
      log_n++;
      chk(fifo_data_o == last_data, "R3 data", int'(fifo_data_o), int'(last_data));
      chk(int'(fifo_ch_o) == req_ch_b, "R3 tag", int'(fifo_ch_o), req_ch_b);
      if (fifo_src_o == 2'b00) begin
        scan_res++;
        chk(exp_scan == int'(fifo_ch_o), "R2 R10 order", int'(fifo_ch_o), exp_scan);
        nx = next_set(scan_mask_b, int'(fifo_ch_o) + 1);
        if (nx < 32) exp_scan = nx;
        else begin
          sweeps++;
          exp_scan = rep_b ? next_set(scan_mask_b, 0) : -1;
          chk(scan_busy_o == rep_b, "R4 R5 busy at end", int'(scan_busy_o), int'(rep_b));
        end
      end else begin
        lvl = (fifo_src_o == 2'b01) ? 1 : 2;
        chk(int'(fifo_ch_o) == p_ch_b[lvl], "R9 prio ch", int'(fifo_ch_o), p_ch_b[lvl]);
        p_out[lvl] = 0;
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic begin_scan(input logic [31:0] m, input bit rep);
    scan_mask_b = m;
    rep_b = rep;
    repeat_i = rep;
    exp_scan = next_set(m, 0);
    scan_res = 0;
    sweeps = 0;
    mask_i = m;
    start_i = 1'b1;
    cyc(1);
    start_i = 1'b0;
  endtask

  task automatic wait_idle();
    int guard = 0;
    while ((scan_busy_o || prio_busy_o || cv_cnt != 0 || conv_req_o) && guard < 20000) begin
      cyc(1);
      guard++;
    end
    cyc(3);
  endtask

  task automatic prio_req(input int lvl, input int ch);
    p_ch_b[lvl] = ch;
    p_out[lvl] = 1;
    if (lvl == 1) begin prio1_req_i = 1'b1; prio1_ch_i = 5'(ch); end
    else          begin prio2_req_i = 1'b1; prio2_ch_i = 5'(ch); end
    cyc(1);
    prio1_req_i = 1'b0;
    prio2_req_i = 1'b0;
  endtask

  task automatic wait_req();
    int guard = 0;
    while (!conv_req_o && guard < 1000) begin cyc(1); guard++; end
  endtask

  task automatic finish_up();
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk_i);
    chk(0, "watchdog", 0, 1);
    finish_up();
  end

  initial begin
    int n0, r0;
    logic [31:0] m;
    void'($urandom(32'd20240611));
    p_out[0] = 0; p_out[1] = 0; p_out[2] = 0;
    cyc(3);
    // R1 reset state
    chk(!scan_busy_o && !prio_busy_o, "R1 busy flags", int'({scan_busy_o, prio_busy_o}), 0);
    chk(!conv_req_o && !fifo_wr_o && !conv_abort_o, "R1 outputs",
        int'({conv_req_o, fifo_wr_o, conv_abort_o}), 0);
    rst_ni = 1'b1;
    cyc(2);
    chk(!scan_busy_o && !conv_req_o, "R1 after release", int'(scan_busy_o), 0);

    // R2 R4 sparse one-shot incl. channel 31, plus R7 start while busy
    lat_mode = 0;
    begin_scan(32'h8000_0421, 0);
    chk(scan_busy_o, "R2 busy after start", int'(scan_busy_o), 1);
    cyc(5);
    mask_i = 32'hFFFF_FFFF;
    start_i = 1'b1; cyc(1); start_i = 1'b0;
    wait_idle();
    chk(scan_res == 4, "R2 R7 one pass count", scan_res, 4);
    chk(!scan_busy_o, "R4 stopped", int'(scan_busy_o), 0);
    r0 = req_cnt;
    cyc(20);
    chk(req_cnt == r0, "R4 no more requests", req_cnt, r0);

    // R7 zero mask start
    mask_i = '0;
    start_i = 1'b1; cyc(1); start_i = 1'b0;
    cyc(2);
    chk(!scan_busy_o && req_cnt == r0, "R7 zero mask ignored", int'(scan_busy_o), 0);

    // R5 R6 repeat then clear mid-pass
    begin_scan(32'h0001_0104, 1);
    while (sweeps < 2) cyc(1);
    n0 = scan_res;
    while (scan_res == n0) cyc(1);
    repeat_i = 1'b0;
    rep_b = 0;
    wait_idle();
    chk(sweeps == 3, "R5 R6 sweep count", sweeps, 3);
    chk(scan_res == 9, "R5 R6 result count", scan_res, 9);

    // R9 R10 R11 two-level preemption between channels
    lat_mode = 6;
    log_n = 0;
    begin_scan(32'h0000_0284, 0);
    wait_req();
    cyc(1);
    prio_req(2, 20);
    prio_req(1, 21);
    chk(prio_busy_o, "R11 pending busy", int'(prio_busy_o), 1);
    wait_idle();
    chk(log_n == 5, "R9 result count", log_n, 5);
    chk(log_src[0] == 0 && log_ch[0] == 2, "R10 first scan", log_ch[0], 2);
    chk(log_src[1] == 1 && log_ch[1] == 21, "R9 level1 first", log_src[1], 1);
    chk(log_src[2] == 2 && log_ch[2] == 20, "R9 level2 second", log_src[2], 2);
    chk(log_src[3] == 0 && log_ch[3] == 7, "R10 resume", log_ch[3], 7);
    chk(log_src[4] == 0 && log_ch[4] == 9, "R10 last", log_ch[4], 9);

    // R11 priority with no scan
    log_n = 0;
    prio_req(2, 13);
    chk(prio_busy_o && !scan_busy_o, "R11 prio alone", int'(prio_busy_o), 1);
    wait_idle();
    chk(log_n == 1 && log_src[0] == 2 && log_ch[0] == 13, "R9 R11 prio alone result",
        log_ch[0], 13);
    chk(!prio_busy_o, "R11 prio done", int'(prio_busy_o), 0);

    // R8 forced stop mid-conversion with pending priority
    begin_scan(32'h0000_00F0, 1);
    wait_req();
    prio_req(1, 3);
    cyc(1);
    n0 = log_n;
    stop_i = 1'b1; cyc(1); stop_i = 1'b0;
    chk(!scan_busy_o && !prio_busy_o, "R8 flags cleared", int'({scan_busy_o, prio_busy_o}), 0);
    chk(conv_abort_o, "R8 abort pulse", int'(conv_abort_o), 1);
    p_out[1] = 0;
    exp_scan = -1;
    cyc(15);
    chk(log_n == n0, "R8 in-flight dropped", log_n, n0);
    repeat_i = 1'b0;

    // random scans with random preemption
    for (int it = 0; it < 40; it++) begin
      int g;
      m = $urandom & $urandom;
      if (it % 3 == 0) m = m & $urandom;
      if (m == 0) m = 32'h1 << ($urandom % 32);
      lat_mode = (it % 4 == 0) ? 0 : 1 + int'($urandom % 4);
      begin_scan(m, 0);
      g = 0;
      while (scan_busy_o && g < 5000) begin
        if (($urandom % 16) == 0 && !p_out[1]) prio_req(1, int'($urandom % 32));
        else if (($urandom % 16) == 0 && !p_out[2]) prio_req(2, int'($urandom % 32));
        else cyc(1);
        g++;
      end
      wait_idle();
      chk(scan_res == popc(m), "R2 random pass count", scan_res, popc(m));
      chk(!p_out[1] && !p_out[2], "R9 prio served", int'({p_out[1], p_out[2]}), 0);
    end
    finish_up();
  end
endmodule